// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block turns asynchronous serial frames on one receive line into parallel data words. It has no divider of its own. An external strobe `os_tick`, pulsed for one clock at 16 times the bit rate, paces every decision the block makes. The receive line first passes through a two-stage synchronizer. A low level then counts as a start bit only once it has been seen low on eight ticks in a row. Anything shorter is treated as noise, and the receiver goes back to watching the line.

After a start bit is accepted, the receiver samples each following bit once, sixteen ticks after the previous sample, which places the sample near the middle of the bit. It shifts in the data bits least significant first. If parity is enabled it reads one parity bit, and then it reads the stop bit. Only the data byte reaches the host. The byte sits in a hold register together with a framing flag and a parity flag. A valid flag stays high until the host pulses `rd_ack`. If a second word completes while the first is still unread, the overrun flag is set.

Top module: `serial_rx_os16`

## Requirements
- R1: After reset, `rx_valid`, `rx_frame_err`, `rx_par_err` and `rx_overrun` are 0 and `rx_data` is 0.
- R2: A low level on `rxd` seen on fewer than 8 consecutive ticks (for example 6 or 7) starts no word, and no word is reported. A start bit qualifies on the 8th consecutive low tick.
- R3: The data bits are taken one per 16 ticks after qualification, least significant bit first. The 8-bit word appears on `rx_data` with `rx_valid` = 1 by the end of the stop bit.
- R4: With `par_en` = 1, one parity bit follows the data. `par_odd` = 0 expects even parity and 1 expects odd parity, where the parity covers the data bits plus the parity bit. On a mismatch, `rx_par_err` is 1 together with the word.
- R5: With `par_en` = 0, no parity bit is read: the bit after the data is the stop bit, and `rx_par_err` stays 0.
- R6: If the stop bit is sampled as 0, the word is still delivered, with `rx_frame_err` = 1. A correct stop bit gives `rx_frame_err` = 0.
- R7: `rx_valid` and the word stay unchanged until `rd_ack` is pulsed. The cycle after `rd_ack`, `rx_valid`, `rx_frame_err`, `rx_par_err` and `rx_overrun` are 0.
- R8: If a word completes while `rx_valid` = 1 and no `rd_ack` arrives in the same cycle, `rx_overrun` becomes 1 and `rx_data` holds the newer word.
- R9: After the stop sample the receiver is immediately ready again. A start bit that follows the stop bit with no idle time is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| os_tick | input | 1 | One-cycle strobe at 16 times the bit rate |
| rxd | input | 1 | Asynchronous serial input, idles high |
| par_en | input | 1 | 1: a parity bit follows the data |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| rd_ack | input | 1 | Host pulse: word has been read |
| rx_data | output | 8 | Last received data byte |
| rx_valid | output | 1 | An unread word is held |
| rx_frame_err | output | 1 | Stop bit of the held word read as 0 |
| rx_par_err | output | 1 | Parity of the held word did not match |
| rx_overrun | output | 1 | A word arrived while the previous was unread |

## Verification
The assertions assume that `par_en` and `par_odd` change only while the receiver is idle, and that `os_tick` is a single-cycle pulse, never high on two adjacent clocks. The bench produces the tick as one clock high in every two. It changes the parity settings only after a word has been acknowledged and the line has been idle. Every line transition is driven on the falling clock edge, for a whole number of tick periods, so the number of ticks that see each low pulse is exact.

// File: rtl/sr_rx_pkg.sv
// Shared types for the oversampling serial receiver.
// Assumes nothing beyond being compiled before the modules that use it.
package sr_rx_pkg;

    // Receiver sequencing phases
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP
    } rx_state_e;

endpackage

// File: rtl/sr_rx_sync.sv
// Multi-stage synchronizer for a single asynchronous level.
// Assumes the input is a slow level (many clocks per change).
module sr_rx_sync #(
    parameter int  STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain;

    // Shift the raw level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {STAGES{RESET_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], async_in};
        end
    end

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/sr_rx_frame.sv
// Frame sequencer: qualifies the start bit, samples data, parity and
// stop bits on the oversampling tick, and emits a one-cycle word_done.
// Assumes os_tick is a single-cycle strobe and that par_en/par_odd
// only change while idle.
module sr_rx_frame
    import sr_rx_pkg::*;
#(
    parameter int OS_RATE   = 16,
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 os_tick,
    input  logic                 rxd_s,
    input  logic                 par_en,
    input  logic                 par_odd,
    output logic                 word_done,
    output logic [DATA_BITS-1:0] word_data,
    output logic                 word_ferr,
    output logic                 word_perr
);

    localparam int CNT_W = $clog2(OS_RATE);
    localparam int BIT_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OS_RATE / 2 - 1);
    localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(OS_RATE - 1);
    localparam logic [BIT_W-1:0] IDX_LAST  = BIT_W'(DATA_BITS - 1);

    rx_state_e            state;
    logic [CNT_W-1:0]     tick_cnt;
    logic [BIT_W-1:0]     bit_idx;
    logic [DATA_BITS-1:0] shreg;
    logic                 par_bit;

    // Tick-paced sequencing of one frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= RX_IDLE;
            tick_cnt  <= '0;
            bit_idx   <= '0;
            shreg     <= '0;
            par_bit   <= 1'b0;
            word_done <= 1'b0;
            word_ferr <= 1'b0;
            word_perr <= 1'b0;
        end else begin
            word_done <= 1'b0;
            if (os_tick) begin
                unique case (state)
                    RX_IDLE: begin
                        if (!rxd_s) begin
                            state    <= RX_START;
                            tick_cnt <= CNT_W'(1);
                        end
                    end
                    RX_START: begin
                        if (rxd_s) begin
                            state <= RX_IDLE;
                        end else if (tick_cnt == HALF_LAST) begin
                            state    <= RX_DATA;
                            tick_cnt <= '0;
                            bit_idx  <= '0;
                        end else begin
                            tick_cnt <= tick_cnt + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (tick_cnt == BIT_LAST) begin
                            tick_cnt <= '0;
                            shreg    <= {rxd_s, shreg[DATA_BITS-1:1]};
                            if (bit_idx == IDX_LAST) begin
                                state <= par_en ? RX_PARITY : RX_STOP;
                            end else begin
                                bit_idx <= bit_idx + 1'b1;
                            end
                        end else begin
                            tick_cnt <= tick_cnt + 1'b1;
                        end
                    end
                    RX_PARITY: begin
                        if (tick_cnt == BIT_LAST) begin
                            tick_cnt <= '0;
                            par_bit  <= rxd_s;
                            state    <= RX_STOP;
                        end else begin
                            tick_cnt <= tick_cnt + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (tick_cnt == BIT_LAST) begin
                            tick_cnt  <= '0;
                            word_done <= 1'b1;
                            word_ferr <= ~rxd_s;
                            word_perr <= par_en & (par_bit ^ (^shreg) ^ par_odd);
                            state     <= RX_IDLE;
                        end else begin
                            tick_cnt <= tick_cnt + 1'b1;
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

    assign word_data = shreg;

    // R2: a high sample during start qualification abandons the frame
    p_noise_back_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_START && os_tick && rxd_s) |=> (state == RX_IDLE));

    // R2: data phase is only entered from start qualification on a low line
    p_enter_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_DATA && $past(state) != RX_DATA)
            |-> ($past(state) == RX_START && !$past(rxd_s)));

    // R9: the completion strobe lasts exactly one cycle
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |=> !word_done);

endmodule

// File: rtl/sr_rx_hold.sv
// Host-side hold register: keeps the last word and its flags until
// acknowledged, and raises overrun when a word lands on an unread one.
// Assumes word_done is a single-cycle pulse with its data stable.
module sr_rx_hold #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 word_done,
    input  logic [DATA_BITS-1:0] word_data,
    input  logic                 word_ferr,
    input  logic                 word_perr,
    input  logic                 rd_ack,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_valid,
    output logic                 rx_frame_err,
    output logic                 rx_par_err,
    output logic                 rx_overrun
);

    // Capture new words and clear state on acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data      <= '0;
            rx_valid     <= 1'b0;
            rx_frame_err <= 1'b0;
            rx_par_err   <= 1'b0;
            rx_overrun   <= 1'b0;
        end else if (word_done) begin
            rx_data      <= word_data;
            rx_valid     <= 1'b1;
            rx_frame_err <= word_ferr;
            rx_par_err   <= word_perr;
            rx_overrun   <= (rx_valid | rx_overrun) & ~rd_ack;
        end else if (rd_ack) begin
            rx_valid     <= 1'b0;
            rx_frame_err <= 1'b0;
            rx_par_err   <= 1'b0;
            rx_overrun   <= 1'b0;
        end
    end

    // R7: a completed word is presented as valid
    p_valid_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |=> rx_valid);

    // R7: acknowledge without a new word empties the register
    p_ack_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !word_done) |=> (!rx_valid && !rx_overrun));

    // R8: a word landing on an unread one flags overrun
    p_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && rx_valid && !rd_ack) |=> rx_overrun);

    // R6: error flags only accompany a held word
    p_ferr_needs_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_frame_err |-> rx_valid);

endmodule

// File: rtl/serial_rx_os16.sv
// Top of the oversampling serial receiver: synchronizer, frame
// sequencer and host hold register. Assumes os_tick runs at OS_RATE
// times the bit rate and parity settings change only while idle.
module serial_rx_os16 #(
    parameter int OS_RATE     = 16,
    parameter int DATA_BITS   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 os_tick,
    input  logic                 rxd,
    input  logic                 par_en,
    input  logic                 par_odd,
    input  logic                 rd_ack,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_valid,
    output logic                 rx_frame_err,
    output logic                 rx_par_err,
    output logic                 rx_overrun
);

    logic                 rxd_s;
    logic                 word_done;
    logic [DATA_BITS-1:0] word_data;
    logic                 word_ferr;
    logic                 word_perr;

    sr_rx_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (rxd),
        .sync_out (rxd_s)
    );

    sr_rx_frame #(
        .OS_RATE   (OS_RATE),
        .DATA_BITS (DATA_BITS)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .os_tick   (os_tick),
        .rxd_s     (rxd_s),
        .par_en    (par_en),
        .par_odd   (par_odd),
        .word_done (word_done),
        .word_data (word_data),
        .word_ferr (word_ferr),
        .word_perr (word_perr)
    );

    sr_rx_hold #(
        .DATA_BITS (DATA_BITS)
    ) u_hold (
        .clk          (clk),
        .rst_n        (rst_n),
        .word_done    (word_done),
        .word_data    (word_data),
        .word_ferr    (word_ferr),
        .word_perr    (word_perr),
        .rd_ack       (rd_ack),
        .rx_data      (rx_data),
        .rx_valid     (rx_valid),
        .rx_frame_err (rx_frame_err),
        .rx_par_err   (rx_par_err),
        .rx_overrun   (rx_overrun)
    );

    // R5: without parity enabled no parity error is reported
    p_par_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && !par_en) |=> !rx_par_err);

endmodule

// File: tb/test_serial_rx_os16.sv
module test_serial_rx_os16;

    localparam int TICK_CLKS = 2;
    localparam int BIT_CLKS  = 16 * TICK_CLKS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       rd_ack = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_frame_err;
    logic       rx_par_err;
    logic       rx_overrun;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    serial_rx_os16 i_serial_rx_os16 (
        .clk          (clk),
        .rst_n        (rst_n),
        .os_tick      (os_tick),
        .rxd          (rxd),
        .par_en       (par_en),
        .par_odd      (par_odd),
        .rd_ack       (rd_ack),
        .rx_data      (rx_data),
        .rx_valid     (rx_valid),
        .rx_frame_err (rx_frame_err),
        .rx_par_err   (rx_par_err),
        .rx_overrun   (rx_overrun)
    );

    always #10 clk = ~clk;

    // Tick: one clock high in every TICK_CLKS
    initial begin
        forever begin
            @(negedge clk) os_tick = 1'b1;
            repeat (TICK_CLKS - 1) @(negedge clk) os_tick = 1'b0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive(input logic v, input int n);
        rxd = v;
        wait_clks(n);
    endtask

    task automatic send_frame(input logic [7:0] d, input bit with_par,
                              input bit par_val, input bit stop_val,
                              input int stop_clks);
        drive(1'b0, BIT_CLKS);
        for (int i = 0; i < 8; i++) drive(d[i], BIT_CLKS);
        if (with_par) drive(par_val, BIT_CLKS);
        drive(stop_val, stop_clks);
        rxd = 1'b1;
    endtask

    task automatic ack;
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        wait_clks(5);
        rst_n = 1'b1;
        wait_clks(2);

        // R1: reset state
        chk("R1 valid", rx_valid, 0);
        chk("R1 flags", {rx_frame_err, rx_par_err, rx_overrun}, 0);
        chk("R1 data", rx_data, 0);

        // R2: short low pulses of 6 and 7 ticks are rejected
        drive(1'b0, 6 * TICK_CLKS);
        drive(1'b1, 3 * BIT_CLKS);
        chk("R2 6-tick glitch", rx_valid, 0);
        drive(1'b0, 7 * TICK_CLKS);
        drive(1'b1, 3 * BIT_CLKS);
        chk("R2 7-tick glitch", rx_valid, 0);
        // R2: glitch then a real frame
        drive(1'b0, 6 * TICK_CLKS);
        drive(1'b1, BIT_CLKS);
        send_frame(8'hA5, 0, 0, 1, BIT_CLKS);
        chk("R2 frame after glitch", rx_data, 8'hA5);
        chk("R2 valid after glitch", rx_valid, 1);
        ack();

        // R3/R5/R7: every byte without parity
        for (int b = 0; b < 256; b++) begin
            send_frame(8'(b), 0, 0, 1, BIT_CLKS);
            chk("R3 data", rx_data, b);
            chk("R3 valid", rx_valid, 1);
            chk("R5 par_err off", rx_par_err, 0);
            chk("R6 good stop", rx_frame_err, 0);
            ack();
            chk("R7 ack clears", {rx_valid, rx_overrun}, 0);
        end

        // R7: word held while unacknowledged
        send_frame(8'h5A, 0, 0, 1, BIT_CLKS);
        wait_clks(3 * BIT_CLKS);
        chk("R7 held valid", rx_valid, 1);
        chk("R7 held data", rx_data, 8'h5A);
        ack();
        chk("R7 cleared", rx_valid, 0);

        // R6: bad stop bit, short so no false start follows
        send_frame(8'h3C, 0, 0, 0, 12 * TICK_CLKS);
        wait_clks(BIT_CLKS);
        chk("R6 valid", rx_valid, 1);
        chk("R6 frame_err", rx_frame_err, 1);
        chk("R6 data", rx_data, 8'h3C);
        ack();
        chk("R7 frame_err cleared", rx_frame_err, 0);
        wait_clks(2 * BIT_CLKS);
        chk("R6 no spurious word", rx_valid, 0);

        // R4: parity, even and odd, good and bad alternately
        par_en = 1'b1;
        for (int odd = 0; odd < 2; odd++) begin
            par_odd = odd[0];
            wait_clks(BIT_CLKS);
            for (int i = 0; i < 32; i++) begin
                logic [7:0] d;
                logic       good_p;
                bit         bad;
                d      = 8'(i * 37 + odd * 11);
                good_p = (^d) ^ odd[0];
                bad    = i[0];
                send_frame(d, 1, good_p ^ bad, 1, BIT_CLKS);
                chk("R4 data", rx_data, d);
                chk("R4 par_err", rx_par_err, bad);
                chk("R4 frame_err", rx_frame_err, 0);
                ack();
            end
        end
        par_en = 1'b0;
        par_odd = 1'b0;
        wait_clks(BIT_CLKS);

        // R8/R9: back-to-back frames without acknowledge
        send_frame(8'h11, 0, 0, 1, BIT_CLKS);
        send_frame(8'h22, 0, 0, 1, BIT_CLKS);
        chk("R9 second word caught", rx_data, 8'h22);
        chk("R8 overrun", rx_overrun, 1);
        chk("R8 valid", rx_valid, 1);
        ack();
        chk("R8 overrun cleared", rx_overrun, 0);

        finish_run();
    end

endmodule